// File: doc/BRIEF.md
# Serial Receive Interrupt Event Selector

This block turns receiver events of a serial port into interrupt requests. It drives two lines. The first is a dedicated receive interrupt. A 2-bit mode input picks which one of four events drives it: the receive-ready flag rising, an end-of-frame strobe, a new frame-sync pulse, or the sync-error flag rising. The end-of-frame choice only fires while multichannel selection is active. The line gives a single-cycle pulse for each selected event.

The second line is a shared interrupt. It has a four-bit enable register and a four-bit sticky status register, and status bits are cleared by writing ones. Every event sets its status bit whatever the enables hold and whatever the mode is, including end-of-frame outside multichannel selection. The shared line is high while any status bit is set together with its enable.

The frame-sync input comes from outside the clock domain. It passes through a two-flop synchronizer and a rising-edge detector, so each external pulse gives exactly one clock-wide event. The receiver's own reset state does not gate it. A small register port holds the enables and status, and lets software read back the live ready and sync-error flags.

Top module: `rx_irq_selector`

## Requirements
- R1: With mode 00, each 0-to-1 transition of `rdy_lvl` produces a `rx_irq` pulse in the cycle after the clock edge that samples the new level.
- R2: With mode 01, an `eof_pulse` produces a `rx_irq` pulse one cycle later only if `mc_active` is 1. With `mc_active` 0 it produces none.
- R3: With mode 10, a rising edge on the asynchronous `fs_async` produces exactly one `rx_irq` pulse, which is high after the third clock edge that sees the new level. No other input suppresses it.
- R4: With mode 11, each 0-to-1 transition of `serr_lvl` produces a `rx_irq` pulse in the cycle after the edge that samples it.
- R5: `rx_irq` is high for one cycle per event. A level held high does not repeat the pulse, and events not chosen by the mode never raise it.
- R6: Reading address 2 returns `rdy_lvl` in bit 0 and `serr_lvl` in bit 1, with the other bits zero, in every mode. `rd_data` shows the value for `rd_addr` as sampled at the previous clock edge.
- R7: The status register is at address 1, with bit 0 for ready, bit 1 for end-of-frame, bit 2 for frame-sync and bit 3 for sync-error. A bit sets on its event whatever the enables hold, and sets on end-of-frame whatever `mc_active` is. It stays set until a write to address 1 with a 1 in that bit position.
- R8: The enable register is at address 0, with the same bit order as status. `common_irq` equals the OR of (status AND enable), and it changes on the same edge as the status and enable registers.
- R9: When a clearing write and a new event for the same status bit fall in the same cycle, the bit remains set.
- R10: After reset, `rx_irq`, `common_irq`, `rd_data`, the status register and the enable register are all zero. Writes to address 2 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Event selection for `rx_irq` (00 ready, 01 end-of-frame, 10 frame-sync, 11 sync-error) |
| mc_active | input | 1 | Multichannel selection mode is active |
| rdy_lvl | input | 1 | Receive-ready flag level |
| eof_pulse | input | 1 | Single-cycle end-of-frame strobe |
| fs_async | input | 1 | External frame-sync, asynchronous |
| serr_lvl | input | 1 | Frame-sync error flag level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 4 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 4 | Registered read data |
| rx_irq | output | 1 | Mode-selected receive interrupt pulse |
| common_irq | output | 1 | Shared interrupt level |

## Verification
The bench targets end-of-frame outside multichannel mode. A design that gated the status bit as well as the legacy line would lose the status bit, and one that did not gate the legacy line would pulse it. It times the frame-sync path edge by edge and holds the pulse long: a missing synchronizer stage shifts the pulse, and a missing edge detector gives a level instead of one pulse. It lands a clearing write on the same cycle as a new ready event, where a design that let the clear win would drop the event. Random traffic with changing modes, enables and writes to unused addresses exposes stray pulses, lost sticky bits and a shared line that lags its status by a cycle.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  localparam int NUM_EV = 4;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    EV_RDY  = 2'd0,
    EV_EOF  = 2'd1,
    EV_FS   = 2'd2,
    EV_SERR = 2'd3
  } ev_e;

  localparam int REG_EN   = 0;
  localparam int REG_ST   = 1;
  localparam int REG_FLAG = 2;
endpackage

// File: rtl/rxirq_fs_sync.sv
module rxirq_fs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_in,
  output logic fs_rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], fs_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fs_rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rxirq_rise.sv
module rxirq_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  // The previous level follows the input during reset too, so a flag
  // already high when reset ends is not reported as a new rise.
  always_ff @(posedge clk) prev_q <= lvl;

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/rxirq_regs.sv
module rxirq_regs import rxirq_pkg::*; #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic              rdy_lvl,
  input  logic              serr_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NUM_EV-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_EV-1:0] rd_data,
  output logic [NUM_EV-1:0] st_q,
  output logic [NUM_EV-1:0] en_q,
  output logic              common_irq
);
  logic [NUM_EV-1:0] clr_mask, st_nxt, en_nxt;
  logic [NUM_EV-1:0] flag_word;

  always_comb begin
    clr_mask = (wr_en && wr_addr == ADDR_W'(REG_ST)) ? wr_data : '0;
    st_nxt   = (st_q & ~clr_mask) | ev;
    en_nxt   = (wr_en && wr_addr == ADDR_W'(REG_EN)) ? wr_data : en_q;
    flag_word = '0;
    flag_word[0] = rdy_lvl;
    flag_word[1] = serr_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= '0;
      en_q       <= '0;
      common_irq <= 1'b0;
      rd_data    <= '0;
    end else begin
      st_q       <= st_nxt;
      en_q       <= en_nxt;
      common_irq <= |(st_nxt & en_nxt);
      if (rd_addr == ADDR_W'(REG_EN))        rd_data <= en_q;
      else if (rd_addr == ADDR_W'(REG_ST))   rd_data <= st_q;
      else if (rd_addr == ADDR_W'(REG_FLAG)) rd_data <= flag_word;
      else                                   rd_data <= '0;
    end
  end
endmodule

// File: rtl/rx_irq_selector.sv
module rx_irq_selector import rxirq_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              mc_active,
  input  logic              rdy_lvl,
  input  logic              eof_pulse,
  input  logic              fs_async,
  input  logic              serr_lvl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NUM_EV-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_EV-1:0] rd_data,
  output logic              rx_irq,
  output logic              common_irq
);
  logic [1:0]        lvl_rise;
  logic              fs_rise;
  logic [NUM_EV-1:0] ev_vec;
  logic [NUM_EV-1:0] st_vec, en_vec;
  logic              legacy_sel;

  rxirq_rise #(.W(2)) u_rise (
    .clk  (clk),
    .lvl  ({serr_lvl, rdy_lvl}),
    .rise (lvl_rise)
  );

  rxirq_fs_sync #(.STAGES(SYNC_STAGES)) u_fs (
    .clk     (clk),
    .rst     (rst),
    .fs_in   (fs_async),
    .fs_rise (fs_rise)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[EV_RDY]  = lvl_rise[0];
    ev_vec[EV_EOF]  = eof_pulse;
    ev_vec[EV_FS]   = fs_rise;
    ev_vec[EV_SERR] = lvl_rise[1];
  end

  // The legacy line gates end-of-frame on multichannel mode; the shared path does not.
  always_comb begin
    legacy_sel = ev_vec[mode];
    if (mode == EV_EOF) legacy_sel = legacy_sel & mc_active;
  end

  always_ff @(posedge clk) begin
    if (rst) rx_irq <= 1'b0;
    else     rx_irq <= legacy_sel;
  end

  rxirq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev_vec),
    .rdy_lvl    (rdy_lvl),
    .serr_lvl   (serr_lvl),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .st_q       (st_vec),
    .en_q       (en_vec),
    .common_irq (common_irq)
  );
endmodule

// File: rtl/rx_irq_selector_chk.sv
module rx_irq_selector_chk import rxirq_pkg::*; #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode,
  input logic              mc_active,
  input logic              rdy_lvl,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NUM_EV-1:0] wr_data,
  input logic [NUM_EV-1:0] ev_vec,
  input logic [NUM_EV-1:0] st_vec,
  input logic [NUM_EV-1:0] en_vec,
  input logic              rx_irq,
  input logic              common_irq
);
  logic st_write;
  assign st_write = wr_en && (wr_addr == ADDR_W'(REG_ST));

  AST_EOF_GATED: assert property (@(posedge clk) disable iff (rst)
    (mode == EV_EOF && !mc_active) |=> !rx_irq); // R2

  AST_READY_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode == EV_RDY && rdy_lvl && $past(rdy_lvl)) |=> !rx_irq); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !st_write |=> ((st_vec & $past(st_vec)) == $past(st_vec))); // R7

  AST_COMMON_LINE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (common_irq == |(st_vec & en_vec))); // R8

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (st_write && wr_data[EV_RDY] && ev_vec[EV_RDY]) |=> st_vec[EV_RDY]); // R9
endmodule

bind rx_irq_selector rx_irq_selector_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .mc_active  (mc_active),
  .rdy_lvl    (rdy_lvl),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .ev_vec     (ev_vec),
  .st_vec     (st_vec),
  .en_vec     (en_vec),
  .rx_irq     (rx_irq),
  .common_irq (common_irq)
);

// File: tb/rx_irq_selector_bench.sv
`timescale 1ns/1ps
module rx_irq_selector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       mc_active = 1'b0, rdy_lvl = 1'b0, eof_pulse = 1'b0;
  logic       fs_async = 1'b0, serr_lvl = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] rd_data;
  logic       rx_irq, common_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R10";

  always #2.5 clk = ~clk;

  rx_irq_selector u_rx_irq_selector (
    .clk(clk), .rst(rst), .mode(mode), .mc_active(mc_active),
    .rdy_lvl(rdy_lvl), .eof_pulse(eof_pulse), .fs_async(fs_async),
    .serr_lvl(serr_lvl), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_irq(rx_irq), .common_irq(common_irq)
  );

  // Reference model built from the requirements
  logic [3:0] m_st = 0, m_en = 0, m_rd = 0;
  logic       m_irq = 0, m_cirq = 0, m_rdy_q = 0, m_serr_q = 0;
  logic       f1 = 0, f2 = 0, f3 = 0;

  function automatic logic [3:0] next_status(logic [3:0] st, logic [3:0] ev,
                                             logic we, logic [1:0] wa, logic [3:0] wd);
    logic [3:0] clr = (we && wa == 2'd1) ? wd : 4'd0;
    return (st & ~clr) | ev;
  endfunction

  function automatic logic legacy(logic [1:0] md, logic [3:0] ev, logic mc);
    case (md)
      2'd0: return ev[0];
      2'd1: return ev[1] & mc;
      2'd2: return ev[2];
      default: return ev[3];
    endcase
  endfunction

  function automatic logic [3:0] read_word(logic [1:0] a, logic [3:0] en,
                                           logic [3:0] st, logic r, logic s);
    case (a)
      2'd0: return en;
      2'd1: return st;
      2'd2: return {2'b00, s, r};
      default: return 4'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [3:0] ev, stn, enn;
    if (rst) begin
      m_st <= 0; m_en <= 0; m_rd <= 0; m_irq <= 0; m_cirq <= 0;
      f1 <= 0; f2 <= 0; f3 <= 0;
    end else begin
      ev  = {serr_lvl & ~m_serr_q, f2 & ~f3, eof_pulse, rdy_lvl & ~m_rdy_q};
      stn = next_status(m_st, ev, wr_en, wr_addr, wr_data);
      enn = (wr_en && wr_addr == 2'd0) ? wr_data : m_en;
      m_irq  <= legacy(mode, ev, mc_active);
      m_cirq <= |(stn & enn);
      m_rd   <= read_word(rd_addr, m_en, m_st, rdy_lvl, serr_lvl);
      m_st <= stn; m_en <= enn;
      f1 <= fs_async; f2 <= f1; f3 <= f2;
    end
    m_rdy_q <= rdy_lvl; m_serr_q <= serr_lvl;
  end

  task automatic chk(string t, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // Advance one cycle and compare all outputs to the model
  task automatic tick();
    @(posedge clk); @(negedge clk);
    chk({tag, " rx_irq"}, {3'b0, rx_irq}, {3'b0, m_irq});
    chk({tag, " common_irq"}, {3'b0, common_irq}, {3'b0, m_cirq});
    chk({tag, " rd_data"}, rd_data, m_rd);
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [3:0] v);
    rd_addr = a; tick(); v = rd_data;
  endtask

  task automatic count_pulses(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin tick(); c += rx_irq; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    int c;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R10";
    @(negedge clk);
    chk("R10 reset rx_irq", {3'b0, rx_irq}, 4'd0);
    chk("R10 reset common", {3'b0, common_irq}, 4'd0);
    chk("R10 reset rd_data", rd_data, 4'd0);
    rd(2'd1, v); chk("R10 reset status", v, 4'd0);
    rd(2'd0, v); chk("R10 reset enable", v, 4'd0);

    // R1 / R5: ready rise gives one pulse while held high
    tag = "R1"; mode = 2'd0;
    rdy_lvl = 1; tick();
    chk("R1 pulse after rise", {3'b0, rx_irq}, 4'd1);
    count_pulses(6, c);
    chk("R5 no repeat while ready held", c[3:0], 4'd0);
    rdy_lvl = 0; tick();

    // R2: eof gated by multichannel mode on legacy line, not in status
    tag = "R2"; mode = 2'd1; mc_active = 0;
    wr(2'd1, 4'hF);
    eof_pulse = 1; tick(); eof_pulse = 0;
    chk("R2 eof without multichannel", {3'b0, rx_irq}, 4'd0);
    rd(2'd1, v); rd(2'd1, v);
    chk("R7 eof status set without multichannel", v & 4'h2, 4'h2);
    mc_active = 1; eof_pulse = 1; tick(); eof_pulse = 0;
    chk("R2 eof with multichannel", {3'b0, rx_irq}, 4'd1);

    // R3: fs synchronized, high after third edge, one pulse only
    tag = "R3"; mode = 2'd2; rdy_lvl = 1;
    fs_async = 1;
    tick(); chk("R3 edge1 quiet", {3'b0, rx_irq}, 4'd0);
    tick(); chk("R3 edge2 quiet", {3'b0, rx_irq}, 4'd0);
    tick(); chk("R3 edge3 pulse", {3'b0, rx_irq}, 4'd1);
    count_pulses(5, c);
    chk("R3 single pulse while fs held", c[3:0], 4'd0);
    fs_async = 0; rdy_lvl = 0; repeat (3) tick();

    // R4: sync error rise
    tag = "R4"; mode = 2'd3;
    serr_lvl = 1; tick();
    chk("R4 pulse on error rise", {3'b0, rx_irq}, 4'd1);
    tick(); chk("R5 one cycle only", {3'b0, rx_irq}, 4'd0);

    // R6: flags readable in any mode
    tag = "R6"; rdy_lvl = 1; mode = 2'd1;
    rd(2'd2, v); rd(2'd2, v);
    chk("R6 flag readback", v, 4'h3);
    serr_lvl = 0; rdy_lvl = 0; tick();

    // R8: shared line follows status AND enable
    tag = "R8";
    wr(2'd1, 4'hF);
    wr(2'd0, 4'h4);
    chk("R8 common low, no status", {3'b0, common_irq}, 4'd0);
    fs_async = 1; repeat (3) tick();
    chk("R8 common high on fs status", {3'b0, common_irq}, 4'd1);
    fs_async = 0;
    wr(2'd1, 4'h4);
    chk("R8 common low after clear", {3'b0, common_irq}, 4'd0);
    repeat (3) tick();

    // R9: event beats clear in same cycle
    tag = "R9";
    wr(2'd1, 4'hF);
    rdy_lvl = 1; wr(2'd1, 4'h1);
    rd(2'd1, v); rd(2'd1, v);
    chk("R9 event wins over clear", v & 4'h1, 4'h1);
    rdy_lvl = 0;

    // R10: writes to addresses 2 and 3 ignored
    tag = "R10";
    wr(2'd0, 4'h9);
    wr(2'd1, 4'hF);
    wr(2'd2, 4'h6); wr(2'd3, 4'hF);
    rd(2'd0, v); rd(2'd0, v);
    chk("R10 enable kept after stray writes", v, 4'h9);
    rd(2'd1, v);
    chk("R10 status kept after stray writes", v, 4'h0);

    // Random traffic checked against the model
    tag = "R5 random";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) mc_active = ~mc_active;
      if ($urandom_range(0, 3) == 0) rdy_lvl = ~rdy_lvl;
      if ($urandom_range(0, 7) == 0) serr_lvl = ~serr_lvl;
      if ($urandom_range(0, 5) == 0) fs_async = ~fs_async;
      eof_pulse = ($urandom_range(0, 5) == 0);
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = 4'($urandom_range(0, 15));
      rd_addr = 2'($urandom_range(0, 3));
      tick();
    end
    wr_en = 0; eof_pulse = 0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule